// File: doc/BRIEF.md
# Hot-Plug Function Event Queue

This block tracks which slots on an I/O bus hold a function and whether each of those functions is configured. It also keeps an ordered queue of pending availability events for the host.

A management port announces hot-plug and hot-unplug of a slot. Each announcement expands into a fixed, ordered pair of state-transition events, or one event in some cases, and these are written into the queue in a single cycle. Whenever at least one event enters the queue, a change-report pulse tells the host to come and collect it.

The host side has one request port with three operations:
- **pop**: takes the oldest event. The response carries the event's identity, a completion code and a "more pending" flag.
- **configure**: sets the configured state of a function, found by its function ID.
- **deconfigure**: clears the configured state of a function, found by its function ID.

Each response is registered and appears exactly one cycle after its request. A sticky overflow flag records any event that was dropped because the queue was full.

Top module: `fnev_hub`

## Requirements
- R1: A plug request for an empty slot S marks S present and configured. In the same cycle it queues two availability events (content code 2), in this order: event code 0x0302, then 0x0301. Both carry function ID = S and handle = S | 0x00FF0000. A plug request for a slot that is already present is ignored and queues nothing.
- R2: An unplug request for a present slot S does the following:
  - If S is configured, it queues 0x0304 and then 0x0308.
  - If S is not configured, it queues only 0x0308.
  - In both cases S becomes absent and unconfigured.
  
  An unplug request for an absent slot is ignored and queues nothing.
- R3: In the cycle after any event is accepted into the queue, `chg_pulse` is high for one cycle. In that cycle `chg_rsc` reads 0xB and `chg_num` gives the number of events accepted (1 or 2). When nothing is accepted, `chg_pulse` stays low.
- R4: A pop (op 0) with `host_mask[61]` set on a non-empty queue returns code 0x0001 together with the oldest entry's function ID, handle, content code and event code. Entries leave the queue in the order they entered.
- R5: A pop on an empty queue, or with `host_mask[61]` clear, returns code 0x0004 with all event fields and flags zero, and leaves the queue unchanged.
- R6: On a delivered pop, `rsp_flags` bit 7 (0x80) is set when further entries remain queued, and is clear otherwise.
- R7: For configure (op 1) and deconfigure (op 2), the response code is:
  - 0x0020 when the request changes the function's state.
  - 0x0120 when the function is already in the requested state.
  - 0x09F0 when the function ID is 32 or more, or names an absent slot.
- R8: An event pushed into a full queue (DEPTH entries) is dropped and sets `ovf_flag`, which stays set until reset. The slot-table update of R1 and R2 still takes place.
- R9: After reset the queue is empty, no slot is present, `ovf_flag` is 0, and `rsp_valid` and `chg_pulse` are low.
- R10: `rsp_valid` is high in the cycle after a host request with op 0, 1 or 2. Op 3 produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_valid | input | 1 | Management request strobe |
| mgmt_plug | input | 1 | 1 = hot-plug, 0 = hot-unplug |
| mgmt_slot | input | $clog2(NSLOT) | Slot addressed by the management request |
| host_valid | input | 1 | Host request strobe |
| host_op | input | 2 | 0 pop, 1 configure, 2 deconfigure, 3 no operation |
| host_mask | input | 64 | Selection mask; bit 61 enables the event queue for pops |
| host_fid | input | 32 | Function ID for configure and deconfigure |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_code | output | 16 | Completion code |
| rsp_flags | output | 8 | Bit 7 = more events pending |
| rsp_cc | output | 8 | Content code of the delivered event |
| rsp_fid | output | 32 | Function ID of the delivered event |
| rsp_fh | output | 32 | Function handle of the delivered event |
| rsp_pec | output | 16 | Event code of the delivered event |
| chg_pulse | output | 1 | Change-report pulse |
| chg_rsc | output | 4 | Change-report resource code (0xB) |
| chg_num | output | 2 | Number of events accepted in the reported cycle |
| ovf_flag | output | 1 | Sticky queue-overflow flag |

## Verification
All results are registered, and each one falls due at a fixed point after its stimulus:
- A management request updates the slot table and the queue at the clock edge that samples it, and `chg_pulse` and `chg_num` read the accepted count right after that edge.
- A host request is answered on `rsp_*` right after the edge that samples it, so a pop issued one cycle after a plug already sees that plug's events.

The bench drives every input on the falling edge, waits for one rising edge, and compares outputs on the following falling edge. Because every check is taken in that single cycle, a response that arrives late or too early shows up as a mismatch. The unplug of an absent slot and a second plug of a present slot are both followed by a pop that must return 0x0004, which shows through the host port that nothing was queued.

// File: rtl/fnev_pkg.sv
package fnev_pkg;

   typedef struct packed {
      logic [31:0] fid;
      logic [31:0] fh;
      logic [7:0]  cc;
      logic [15:0] pec;
   } fnev_entry_t;

   typedef enum logic [1:0] {
      OP_POP   = 2'd0,
      OP_CFG   = 2'd1,
      OP_DECFG = 2'd2,
      OP_NONE  = 2'd3
   } host_op_e;

   // state-transition event codes
   localparam logic [15:0] PEC_RSV_TO_STBY = 16'h0302;
   localparam logic [15:0] PEC_TO_CFG      = 16'h0301;
   localparam logic [15:0] PEC_CFG_TO_OFF  = 16'h0304;
   localparam logic [15:0] PEC_STBY_TO_RSV = 16'h0308;

   // completion codes
   localparam logic [15:0] RC_DELIVERED = 16'h0001;
   localparam logic [15:0] RC_NO_EVENT  = 16'h0004;
   localparam logic [15:0] RC_TOGGLED   = 16'h0020;
   localparam logic [15:0] RC_SAME      = 16'h0120;
   localparam logic [15:0] RC_UNKNOWN   = 16'h09F0;

   localparam logic [31:0] FH_TAG    = 32'h00FF_0000;
   localparam logic [7:0]  CC_AVAIL  = 8'd2;
   localparam logic [7:0]  FLAG_MORE = 8'h80;
   localparam logic [3:0]  CHG_RSC   = 4'hB;
   localparam int          SEL_BIT   = 61;

endpackage

// File: rtl/fnev_fifo.sv
module fnev_fifo
   import fnev_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   wr_cnt,
   input  fnev_entry_t                  wr_a,
   input  fnev_entry_t                  wr_b,
   input  logic                         rd_en,
   output fnev_entry_t                  head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic [1:0]                   acc_cnt,
   output logic                         drop
);
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   if (DEPTH < 2) begin : g_bad_depth
      $error("fnev_fifo: DEPTH must be at least 2");
   end

   fnev_entry_t   mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr, wp1, wp2, rp1;
   logic [CW-1:0] cnt;
   logic [CW:0]   free_w;
   logic          do_rd;

   if (POW2) begin : g_wrap_nat
      assign wp1 = wr_ptr + PW'(1);
      assign wp2 = wr_ptr + PW'(2);
      assign rp1 = rd_ptr + PW'(1);
   end else begin : g_wrap_cmp
      assign wp1 = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      assign wp2 = (wp1    == PW'(DEPTH - 1)) ? '0 : wp1    + PW'(1);
      assign rp1 = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
   end

   assign do_rd  = rd_en && (cnt != '0);
   assign free_w = (CW+1)'(DEPTH) - {1'b0, cnt} + {{CW{1'b0}}, do_rd};

   always_comb begin
      if (free_w >= {{(CW-1){1'b0}}, wr_cnt}) acc_cnt = wr_cnt;
      else                                     acc_cnt = free_w[1:0];
   end
   assign drop  = acc_cnt != wr_cnt;
   assign head  = mem[rd_ptr];
   assign count = cnt;

   always_ff @(posedge clk) begin
      if (acc_cnt != 2'd0) mem[wr_ptr] <= wr_a;
      if (acc_cnt == 2'd2) mem[wp1]    <= wr_b;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (acc_cnt == 2'd1)      wr_ptr <= wp1;
         else if (acc_cnt == 2'd2) wr_ptr <= wp2;
         if (do_rd) rd_ptr <= rp1;
         cnt <= cnt + CW'(acc_cnt) - CW'(do_rd);
      end
   end

   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   p_full_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(DEPTH) && !rd_en && wr_cnt != 2'd0) |=> (cnt == CW'(DEPTH)));

endmodule

// File: rtl/fnev_ftab.sv
module fnev_ftab #(
   parameter int NSLOT = 32,
   parameter int IDW   = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     m_valid,
   input  logic                     m_plug,
   input  logic [$clog2(NSLOT)-1:0] m_slot,
   output logic                     m_present,
   output logic                     m_cfg,
   input  logic                     h_valid,
   input  logic                     h_set,
   input  logic [IDW-1:0]           h_fid,
   output logic                     h_known,
   output logic                     h_cfg
);
   localparam int SW = $clog2(NSLOT);

   if (NSLOT < 2 || IDW <= SW) begin : g_bad_cfg
      $error("fnev_ftab: NSLOT must be >= 2 and fit into IDW");
   end

   logic [NSLOT-1:0] present_q, cfg_q, present_d, cfg_d;
   logic             m_slot_ok, h_in_range;
   logic [SW-1:0]    h_idx;

   assign m_slot_ok  = 32'(m_slot) < NSLOT;
   assign m_present  = m_slot_ok && present_q[m_slot];
   assign m_cfg      = m_slot_ok && cfg_q[m_slot];
   assign h_in_range = h_fid < IDW'(NSLOT);
   assign h_idx      = h_fid[SW-1:0];
   assign h_known    = h_in_range && present_q[h_idx];
   assign h_cfg      = h_in_range && cfg_q[h_idx];

   always_comb begin
      present_d = present_q;
      cfg_d     = cfg_q;
      for (int s = 0; s < NSLOT; s++) begin
         if (m_valid && m_slot_ok && m_slot == SW'(s)) begin
            if (m_plug && !present_q[s]) begin
               present_d[s] = 1'b1;
               cfg_d[s]     = 1'b1;
            end else if (!m_plug && present_q[s]) begin
               present_d[s] = 1'b0;
               cfg_d[s]     = 1'b0;
            end
         end else if (h_valid && h_known && h_idx == SW'(s)) begin
            cfg_d[s] = h_set;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         present_q <= '0;
         cfg_q     <= '0;
      end else begin
         present_q <= present_d;
         cfg_q     <= cfg_d;
      end
   end

   p_plug_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_plug && !m_present && m_slot_ok)
      |=> (present_q[$past(m_slot)] && cfg_q[$past(m_slot)]));

   p_unplug_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_plug && m_present)
      |=> (!present_q[$past(m_slot)] && !cfg_q[$past(m_slot)]));

   p_cfg_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && h_known && !(m_valid && m_slot == h_idx))
      |=> (cfg_q[$past(h_idx)] == $past(h_set)));

endmodule

// File: rtl/fnev_hub.sv
module fnev_hub
   import fnev_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int NSLOT = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mgmt_valid,
   input  logic                     mgmt_plug,
   input  logic [$clog2(NSLOT)-1:0] mgmt_slot,
   input  logic                     host_valid,
   input  logic [1:0]               host_op,
   input  logic [63:0]              host_mask,
   input  logic [31:0]              host_fid,
   output logic                     rsp_valid,
   output logic [15:0]              rsp_code,
   output logic [7:0]               rsp_flags,
   output logic [7:0]               rsp_cc,
   output logic [31:0]              rsp_fid,
   output logic [31:0]              rsp_fh,
   output logic [15:0]              rsp_pec,
   output logic                     chg_pulse,
   output logic [3:0]               chg_rsc,
   output logic [1:0]               chg_num,
   output logic                     ovf_flag
);
   localparam int CW = $clog2(DEPTH + 1);

   logic          m_present, m_cfg, h_known, h_cfg, h_valid, h_set;
   logic          pop_req, pop_hit, drop;
   logic [1:0]    wr_cnt, acc_cnt;
   logic [CW-1:0] q_count;
   fnev_entry_t   ev_a, ev_b, head;
   logic [31:0]   ev_fh;

   assign ev_fh   = FH_TAG | 32'(mgmt_slot);
   assign h_set   = host_op == OP_CFG;
   assign h_valid = host_valid && (host_op == OP_CFG || host_op == OP_DECFG);
   assign pop_req = host_valid && host_op == OP_POP && host_mask[SEL_BIT];
   assign pop_hit = pop_req && q_count != '0;

   // expand a management request into its ordered event pair
   always_comb begin
      wr_cnt = 2'd0;
      ev_a   = '{fid: 32'(mgmt_slot), fh: ev_fh, cc: CC_AVAIL, pec: PEC_STBY_TO_RSV};
      ev_b   = ev_a;
      if (mgmt_valid && mgmt_plug && !m_present) begin
         wr_cnt     = 2'd2;
         ev_a.pec   = PEC_RSV_TO_STBY;
         ev_b.pec   = PEC_TO_CFG;
      end else if (mgmt_valid && !mgmt_plug && m_present) begin
         if (m_cfg) begin
            wr_cnt   = 2'd2;
            ev_a.pec = PEC_CFG_TO_OFF;
         end else begin
            wr_cnt   = 2'd1;
         end
      end
   end

   fnev_ftab #(.NSLOT(NSLOT), .IDW(32)) u_ftab (
      .clk(clk), .rst_n(rst_n),
      .m_valid(mgmt_valid), .m_plug(mgmt_plug), .m_slot(mgmt_slot),
      .m_present(m_present), .m_cfg(m_cfg),
      .h_valid(h_valid), .h_set(h_set), .h_fid(host_fid),
      .h_known(h_known), .h_cfg(h_cfg)
   );

   fnev_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_cnt(wr_cnt), .wr_a(ev_a), .wr_b(ev_b),
      .rd_en(pop_hit), .head(head), .count(q_count),
      .acc_cnt(acc_cnt), .drop(drop)
   );

   assign chg_rsc = CHG_RSC;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_code  <= '0;
         rsp_flags <= '0;
         rsp_cc    <= '0;
         rsp_fid   <= '0;
         rsp_fh    <= '0;
         rsp_pec   <= '0;
         chg_pulse <= 1'b0;
         chg_num   <= '0;
         ovf_flag  <= 1'b0;
      end else begin
         chg_pulse <= acc_cnt != 2'd0;
         chg_num   <= acc_cnt;
         ovf_flag  <= ovf_flag | drop;
         rsp_valid <= host_valid && host_op != OP_NONE;
         if (host_valid && host_op != OP_NONE) begin
            rsp_flags <= '0;
            rsp_cc    <= '0;
            rsp_fid   <= '0;
            rsp_fh    <= '0;
            rsp_pec   <= '0;
            if (host_op == OP_POP) begin
               if (pop_hit) begin
                  rsp_code  <= RC_DELIVERED;
                  rsp_cc    <= head.cc;
                  rsp_fid   <= head.fid;
                  rsp_fh    <= head.fh;
                  rsp_pec   <= head.pec;
                  rsp_flags <= (q_count > CW'(1)) ? FLAG_MORE : 8'h00;
               end else begin
                  rsp_code  <= RC_NO_EVENT;
               end
            end else if (!h_known) begin
               rsp_code <= RC_UNKNOWN;
            end else if (h_cfg == h_set) begin
               rsp_code <= RC_SAME;
            end else begin
               rsp_code <= RC_TOGGLED;
            end
         end
      end
   end

   p_rsp_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && host_op != OP_NONE) |=> rsp_valid);

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   p_masked_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && host_op == OP_POP && !host_mask[SEL_BIT])
      |=> (rsp_code == RC_NO_EVENT && $stable(q_count)));

   p_chg_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chg_pulse |-> (chg_num != 2'd0));

endmodule

// File: tb/fnev_hub_tb.sv
module fnev_hub_tb;
   localparam int  CLK_PERIOD = 10;
   localparam int  WD_CYCLES  = 20000;

   localparam logic [1:0] K_PLUG = 2'd0, K_UNPLUG = 2'd1, K_HOST = 2'd2;

   typedef struct packed {
      logic [1:0]  kind;
      logic [1:0]  op;
      logic [31:0] id;
      logic        msk;
      logic [15:0] ecode;  // response code, or accepted-event count for mgmt steps
      logic [15:0] epec;
      logic        emore;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VEC [NV] = '{
      '{K_PLUG,   2'd0, 32'd3,  1'b0, 16'd2,    16'h0000, 1'b0}, // R1 R3
      '{K_HOST,   2'd0, 32'd3,  1'b1, 16'h0001, 16'h0302, 1'b1}, // R4 R6
      '{K_HOST,   2'd0, 32'd0,  1'b0, 16'h0004, 16'h0000, 1'b0}, // R5 masked
      '{K_HOST,   2'd0, 32'd3,  1'b1, 16'h0001, 16'h0301, 1'b0}, // R4 R6
      '{K_HOST,   2'd0, 32'd0,  1'b1, 16'h0004, 16'h0000, 1'b0}, // R5 empty
      '{K_HOST,   2'd1, 32'd3,  1'b1, 16'h0120, 16'h0000, 1'b0}, // R7
      '{K_HOST,   2'd2, 32'd3,  1'b1, 16'h0020, 16'h0000, 1'b0}, // R7
      '{K_HOST,   2'd2, 32'd3,  1'b1, 16'h0120, 16'h0000, 1'b0}, // R7
      '{K_UNPLUG, 2'd0, 32'd3,  1'b0, 16'd1,    16'h0000, 1'b0}, // R2
      '{K_HOST,   2'd0, 32'd3,  1'b1, 16'h0001, 16'h0308, 1'b0}, // R2
      '{K_HOST,   2'd1, 32'd3,  1'b1, 16'h09F0, 16'h0000, 1'b0}, // R7 absent
      '{K_HOST,   2'd1, 32'd40, 1'b1, 16'h09F0, 16'h0000, 1'b0}, // R7 range
      '{K_PLUG,   2'd0, 32'd5,  1'b0, 16'd2,    16'h0000, 1'b0}, // R1
      '{K_UNPLUG, 2'd0, 32'd5,  1'b0, 16'd2,    16'h0000, 1'b0}, // R2
      '{K_HOST,   2'd0, 32'd5,  1'b1, 16'h0001, 16'h0302, 1'b1}, // R4
      '{K_HOST,   2'd0, 32'd5,  1'b1, 16'h0001, 16'h0301, 1'b1}, // R4
      '{K_HOST,   2'd0, 32'd5,  1'b1, 16'h0001, 16'h0304, 1'b1}, // R2
      '{K_HOST,   2'd0, 32'd5,  1'b1, 16'h0001, 16'h0308, 1'b0}, // R2
      '{K_UNPLUG, 2'd0, 32'd7,  1'b0, 16'd0,    16'h0000, 1'b0}, // R2 absent
      '{K_HOST,   2'd0, 32'd0,  1'b1, 16'h0004, 16'h0000, 1'b0}, // R2 nothing queued
      '{K_PLUG,   2'd0, 32'd5,  1'b0, 16'd2,    16'h0000, 1'b0}, // R1
      '{K_PLUG,   2'd0, 32'd5,  1'b0, 16'd0,    16'h0000, 1'b0}, // R1 replug ignored
      '{K_HOST,   2'd0, 32'd5,  1'b1, 16'h0001, 16'h0302, 1'b1}, // R1
      '{K_HOST,   2'd0, 32'd5,  1'b1, 16'h0001, 16'h0301, 1'b0}, // R1 only two
      '{K_HOST,   2'd1, 32'd5,  1'b1, 16'h0120, 16'h0000, 1'b0}, // R1 configured
      '{K_HOST,   2'd2, 32'd5,  1'b1, 16'h0020, 16'h0000, 1'b0}, // R7
      '{K_HOST,   2'd1, 32'd5,  1'b1, 16'h0020, 16'h0000, 1'b0}  // R7
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        mgmt_valid = 1'b0, mgmt_plug = 1'b0;
   logic [4:0]  mgmt_slot = '0;
   logic        host_valid = 1'b0;
   logic [1:0]  host_op = '0;
   logic [63:0] host_mask = '0;
   logic [31:0] host_fid = '0;
   logic        rsp_valid, chg_pulse, ovf_flag;
   logic [15:0] rsp_code, rsp_pec;
   logic [7:0]  rsp_flags, rsp_cc;
   logic [31:0] rsp_fid, rsp_fh;
   logic [3:0]  chg_rsc;
   logic [1:0]  chg_num;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fnev_hub u_dut (
      .clk(clk), .rst_n(rst_n),
      .mgmt_valid(mgmt_valid), .mgmt_plug(mgmt_plug), .mgmt_slot(mgmt_slot),
      .host_valid(host_valid), .host_op(host_op), .host_mask(host_mask),
      .host_fid(host_fid),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_flags(rsp_flags),
      .rsp_cc(rsp_cc), .rsp_fid(rsp_fid), .rsp_fh(rsp_fh), .rsp_pec(rsp_pec),
      .chg_pulse(chg_pulse), .chg_rsc(chg_rsc), .chg_num(chg_num),
      .ovf_flag(ovf_flag)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic mgmt(input logic plug, input logic [4:0] slot, input int exp_num);
      @(negedge clk);
      mgmt_valid = 1'b1; mgmt_plug = plug; mgmt_slot = slot;
      @(posedge clk);
      @(negedge clk);
      mgmt_valid = 1'b0;
      chk("R3 chg_pulse", 64'(chg_pulse), 64'(exp_num != 0));
      chk("R3 chg_num", 64'(chg_num), 64'(exp_num));
      if (exp_num != 0) chk("R3 chg_rsc", 64'(chg_rsc), 64'hB);
   endtask

   task automatic host(input logic [1:0] op, input logic [31:0] fid, input logic msk,
                       input logic [15:0] ecode, input logic [15:0] epec, input logic emore);
      @(negedge clk);
      host_valid = 1'b1; host_op = op; host_fid = fid;
      host_mask  = msk ? (64'd1 << 61) : 64'h0;
      @(posedge clk);
      @(negedge clk);
      host_valid = 1'b0;
      chk("R10 rsp_valid", 64'(rsp_valid), 64'd1);
      chk("R4/R5/R7 rsp_code", 64'(rsp_code), 64'(ecode));
      if (ecode == 16'h0001) begin
         chk("R4 pec", 64'(rsp_pec), 64'(epec));
         chk("R1 fid", 64'(rsp_fid), 64'(fid));
         chk("R1 fh", 64'(rsp_fh), 64'(fid | 32'h00FF0000));
         chk("R1 cc", 64'(rsp_cc), 64'd2);
         chk("R6 flags", 64'(rsp_flags), emore ? 64'h80 : 64'h0);
      end else if (op == 2'd0) begin
         chk("R5 zero fields", {rsp_pec, rsp_flags, rsp_cc, rsp_fid[15:0], rsp_fh[15:0]}, 64'h0);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R9: reset state
      chk("R9 rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R9 chg_pulse", 64'(chg_pulse), 64'd0);
      chk("R9 ovf_flag", 64'(ovf_flag), 64'd0);
      host(2'd0, 32'd0, 1'b1, 16'h0004, 16'h0, 1'b0);   // R9 queue empty
      host(2'd1, 32'd0, 1'b1, 16'h09F0, 16'h0, 1'b0);   // R9 no function present

      // R10: op 3 gives no response
      @(negedge clk);
      host_valid = 1'b1; host_op = 2'd3;
      @(posedge clk);
      @(negedge clk);
      host_valid = 1'b0;
      chk("R10 no response for op 3", 64'(rsp_valid), 64'd0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].kind == K_HOST)
            host(VEC[i].op, VEC[i].id, VEC[i].msk, VEC[i].ecode, VEC[i].epec, VEC[i].emore);
         else
            mgmt(VEC[i].kind == K_PLUG, VEC[i].id[4:0], int'(VEC[i].ecode));
      end

      // R8: fill the queue, then overflow it
      for (int s = 10; s < 18; s++) mgmt(1'b1, 5'(s), 2);
      chk("R8 no overflow at exactly full", 64'(ovf_flag), 64'd0);
      mgmt(1'b1, 5'd18, 0);
      chk("R8 overflow flag set", 64'(ovf_flag), 64'd1);
      for (int k = 0; k < 16; k++)
         host(2'd0, 32'(10 + k/2), 1'b1, 16'h0001,
              (k % 2 == 0) ? 16'h0302 : 16'h0301, k < 15);
      host(2'd0, 32'd0, 1'b1, 16'h0004, 16'h0, 1'b0);   // R8 dropped events absent
      chk("R8 overflow flag sticky", 64'(ovf_flag), 64'd1);
      host(2'd1, 32'd18, 1'b1, 16'h0120, 16'h0, 1'b0);  // R8 table still updated

      done = 1'b1;
      summary();
      $finish;
   end
endmodule